// File: doc/BRIEF.md
# Multi-lane stream event coder

This block sits behind the symbol decoder of a packetised display main link running one, two or four lanes. Each cycle it takes one decoded 8-bit symbol per lane, each with a flag that marks it as a control character. The input is already decoded from 8b10b and descrambled. From the symbol on lane 0 it tracks where the stream is: active video, filler, a blanking sequence, or a secondary packet. It then produces an 8-bit event code that classifies that state.

The code also carries two error bits. Bit 0 flags that the active lanes disagree. Bit 1 flags a broken consistency rule: a timing or audio field that contradicts the blanking flags, or a lane that has gone too long without a scrambler-reset symbol. A capture front end can use the code to qualify, filter or trigger on traffic. The strobe marks the first state of every recognised packet.

Event code layout: bit 7 is 1 for active video and 0 for blanking. Bit 6 is the field bit in video and the vertical-blanking bit in blanking. Bits 5:2 are the subtype. Bit 1 is the consistency error and bit 0 is the lane mismatch. Control characters are matched by value when the control flag is 1:

| Symbol | Value |
|---|---|
| blank start | 0xBC |
| blank end | 0xFB |
| scrambler reset | 0x1C |
| secondary start | 0x5C |
| secondary end | 0xFD |
| fill start | 0xFE |
| fill end | 0xF7 |

The blanking flag byte uses these bits: bit 0 vertical blanking, bit 1 field, bit 3 no-video, bit 4 audio muted.

Top module: `stream_event_coder`

## Requirements
- R1: While reset is high, and on the first sampling after it, `ev_code` is 0x00 and `pkt_start` is 0.
- R2: A data symbol after a blank end codes as active pixel, {1, F, 0001, 00}. F is bit 1 of the last latched flag byte. The output appears one clock after the input.
- R3: A fill start, the data after it and the fill end all code as filler, {1, F, 0010, 00}. Data after the fill end codes as pixel again.
- R4: A blank start or a scrambler reset codes as {0, V, 0000, 00} with `pkt_start` high, where V is bit 0 of the latched flag byte. The next three data states are the flag byte, the video timing field and the audio timing field, with subtypes 0010, 0011 and 0100. On the flag-byte state, bit 6 is that byte's own bit 0. Later data codes as dummy, subtype 0110.
- R5: A blank end codes as {0, V, 0001} with `pkt_start` high.
- R6: A secondary start codes as subtype 0101 with `pkt_start` high. The state after it sets the packet type. A second secondary start gives 0111 (stream attributes). Data 0x01 gives 1001 (audio timestamp), data 0x02 gives 1000 (audio stream), and any other data gives 1010. That type is held through the secondary end, and dummy follows.
- R7: Bit 0 is set when an active lane's control flag differs from lane 0. It is also set when an active lane's value differs from lane 0 on a control state or on a flag-byte or timing-field state.
- R8: `lane_cnt` 0, 1 and 2 (or 3) select 1, 2 and 4 active lanes. Inactive lanes never set bit 0.
- R9: On the video timing state, bit 1 is set when the latched no-video bit (flag bit 3) is 1 and the field is nonzero.
- R10: On the audio timing state, bit 1 is set when the latched mute bit (flag bit 4) is 1 and the field is nonzero. It is clear when mute is 0.
- R11: Each lane counts blank-end symbols, and a scrambler reset on that lane clears its count. On an active lane, the 512th blank end without a reset sets bit 1 on that blank-end state, and the count starts over.
- R12: Error bits belong to a single state. The following clean state shows both bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_cnt | input | 2 | Active lane count select: 0 one, 1 two, else four |
| lane_data | input | 32 | Decoded symbol per lane, lane 0 in bits 7:0 |
| lane_ctl | input | 4 | Control-character flag per lane |
| ev_code | output | 8 | Registered event code |
| pkt_start | output | 1 | One-cycle strobe on the first state of a recognised packet |

## Verification
The assertions assume that `lane_cnt` is stable across each state and that every input is a known value at each clock edge. The bench meets this by driving all inputs once per cycle on the falling edge and only from tasks. The properties that follow a blank-end count take it that a scrambler reset reaches every active lane in the same state. The stimulus therefore sends resets on all four lanes together, and the missed-reset run lands its 512th blank end exactly where the requirement places it. Lane disagreement is injected only in states whose expected mismatch flag can be stated in advance.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam logic [7:0] SYM_BS = 8'hBC;
    localparam logic [7:0] SYM_BE = 8'hFB;
    localparam logic [7:0] SYM_SR = 8'h1C;
    localparam logic [7:0] SYM_SS = 8'h5C;
    localparam logic [7:0] SYM_SE = 8'hFD;
    localparam logic [7:0] SYM_FS = 8'hFE;
    localparam logic [7:0] SYM_FE = 8'hF7;

    localparam int FLG_VBLANK = 0;
    localparam int FLG_FIELD  = 1;
    localparam int FLG_NOVID  = 3;
    localparam int FLG_MUTE   = 4;

    localparam logic [3:0] ST_START  = 4'd0;
    localparam logic [3:0] ST_BE     = 4'd1;
    localparam logic [3:0] ST_VBID   = 4'd2;
    localparam logic [3:0] ST_MVID   = 4'd3;
    localparam logic [3:0] ST_MAUD   = 4'd4;
    localparam logic [3:0] ST_SSTART = 4'd5;
    localparam logic [3:0] ST_DUMMY  = 4'd6;
    localparam logic [3:0] ST_MSA    = 4'd7;
    localparam logic [3:0] ST_AUD    = 4'd8;
    localparam logic [3:0] ST_ATS    = 4'd9;
    localparam logic [3:0] ST_RSVD   = 4'd10;
    localparam logic [3:0] ST_PIX    = 4'd1;
    localparam logic [3:0] ST_FILL   = 4'd2;

    typedef enum logic [2:0] {
        M_VIDEO, M_FILL, M_VBID, M_MVID, M_MAUD, M_DUMMY, M_SECTYPE, M_SEC
    } mode_e;

    typedef struct packed {
        logic       video;
        logic       sel;
        logic [3:0] sub;
        logic       cons_err;
        logic       mis;
    } evcode_t;

    function automatic logic [3:0] sec_type(input logic [7:0] b);
        if (b == 8'h01)      return ST_ATS;
        else if (b == 8'h02) return ST_AUD;
        else                 return ST_RSVD;
    endfunction

endpackage

// File: rtl/stc_lane_compare.sv
module stc_lane_compare #(
    parameter int LANES = 4,
    parameter int DW    = 8
) (
    input  logic [LANES-1:0][DW-1:0] data,
    input  logic [LANES-1:0]         ctl,
    input  logic [LANES-1:0]         active,
    input  logic                     cmp_data,
    output logic                     mis
);
    always_comb begin
        mis = 1'b0;
        for (int i = 1; i < LANES; i++) begin
            if (active[i]) begin
                if (ctl[i] != ctl[0]) mis = 1'b1;
                if ((ctl[0] || cmp_data) && (data[i] != data[0])) mis = 1'b1;
            end
        end
    end
endmodule

// File: rtl/stc_sr_watch.sv
module stc_sr_watch #(
    parameter int BE_LIMIT = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic is_be,
    input  logic is_sr,
    output logic miss
);
    localparam int CW = (BE_LIMIT > 1) ? $clog2(BE_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(BE_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign miss = is_be && !is_sr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (is_sr)         cnt_q <= '0;
        else if (is_be) begin
            if (cnt_q == LAST)  cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11: a scrambler reset leaves the count empty
    p_sr_clears_r11: assert property (@(posedge clk) disable iff (rst)
        is_sr |=> (cnt_q == '0));

    // R11: after a missed-reset flag the count starts over
    p_miss_restart_r11: assert property (@(posedge clk) disable iff (rst)
        miss |=> (cnt_q == '0));
endmodule

// File: rtl/stc_stream_tracker.sv
module stc_stream_tracker
    import stc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d0,
    input  logic          k0,
    output evcode_t       cls,
    output logic          start,
    output logic          fld_cmp,
    output logic          fld_err,
    output logic          be_seen
);
    mode_e      mode_q, mode_d;
    logic [7:0] flg_q, flg_d;
    logic [3:0] sec_q, sec_d;

    always_comb begin
        mode_d  = mode_q;
        flg_d   = flg_q;
        sec_d   = sec_q;
        cls     = '0;
        cls.sel = flg_q[FLG_VBLANK];
        start   = 1'b0;
        fld_cmp = 1'b0;
        fld_err = 1'b0;
        be_seen = 1'b0;
        if (k0) begin
            case (d0[7:0])
                SYM_BS, SYM_SR: begin
                    cls.sub = ST_START; start = 1'b1; mode_d = M_VBID;
                end
                SYM_BE: begin
                    cls.sub = ST_BE; start = 1'b1; be_seen = 1'b1; mode_d = M_VIDEO;
                end
                SYM_SS: begin
                    if (mode_q == M_SECTYPE) begin
                        cls.sub = ST_MSA; sec_d = ST_MSA; mode_d = M_SEC;
                    end else begin
                        cls.sub = ST_SSTART; start = 1'b1; mode_d = M_SECTYPE;
                    end
                end
                SYM_SE: begin
                    cls.sub = sec_q; mode_d = M_DUMMY;
                end
                SYM_FS, SYM_FE: begin
                    cls.video = 1'b1;
                    cls.sel   = flg_q[FLG_FIELD];
                    cls.sub   = ST_FILL;
                    mode_d    = (d0[7:0] == SYM_FS) ? M_FILL : M_VIDEO;
                end
                default: cls.sub = ST_DUMMY;
            endcase
        end else begin
            case (mode_q)
                M_VIDEO, M_FILL: begin
                    cls.video = 1'b1;
                    cls.sel   = flg_q[FLG_FIELD];
                    cls.sub   = (mode_q == M_VIDEO) ? ST_PIX : ST_FILL;
                end
                M_VBID: begin
                    cls.sel = d0[FLG_VBLANK]; cls.sub = ST_VBID;
                    flg_d = d0[7:0]; fld_cmp = 1'b1; mode_d = M_MVID;
                end
                M_MVID: begin
                    cls.sub = ST_MVID; fld_cmp = 1'b1;
                    fld_err = flg_q[FLG_NOVID] && (d0 != '0);
                    mode_d = M_MAUD;
                end
                M_MAUD: begin
                    cls.sub = ST_MAUD; fld_cmp = 1'b1;
                    fld_err = flg_q[FLG_MUTE] && (d0 != '0);
                    mode_d = M_DUMMY;
                end
                M_SECTYPE: begin
                    cls.sub = sec_type(d0[7:0]); sec_d = cls.sub; mode_d = M_SEC;
                end
                M_SEC:   cls.sub = sec_q;
                default: cls.sub = ST_DUMMY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_DUMMY;
            flg_q  <= '0;
            sec_q  <= ST_RSVD;
        end else begin
            mode_q <= mode_d;
            flg_q  <= flg_d;
            sec_q  <= sec_d;
        end
    end
endmodule

// File: rtl/stream_event_coder.sv
module stream_event_coder
    import stc_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int DW       = 8,
    parameter int BE_LIMIT = 512
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          lane_cnt,
    input  logic [LANES*DW-1:0] lane_data,
    input  logic [LANES-1:0]    lane_ctl,
    output logic [7:0]          ev_code,
    output logic                pkt_start
);
    logic [LANES-1:0][DW-1:0] dat;
    logic [LANES-1:0]         act;
    logic [LANES-1:0]         miss;
    logic                     miss_any, mis, start, fld_cmp, fld_err, be_seen;
    evcode_t                  cls, code_d, code_q;
    logic                     start_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dat[i] = lane_data[i*DW +: DW];
        assign act[i] = (lane_cnt == 2'd0) ? (i == 0) :
                        (lane_cnt == 2'd1) ? (i < 2) : 1'b1;
        stc_sr_watch #(.BE_LIMIT(BE_LIMIT)) i_watch (
            .clk   (clk),
            .rst   (rst),
            .is_be (lane_ctl[i] && dat[i][7:0] == SYM_BE),
            .is_sr (lane_ctl[i] && dat[i][7:0] == SYM_SR),
            .miss  (miss[i])
        );
    end

    assign miss_any = |(miss & act);

    stc_stream_tracker #(.DW(DW)) i_track (
        .clk     (clk),
        .rst     (rst),
        .d0      (dat[0]),
        .k0      (lane_ctl[0]),
        .cls     (cls),
        .start   (start),
        .fld_cmp (fld_cmp),
        .fld_err (fld_err),
        .be_seen (be_seen)
    );

    stc_lane_compare #(.LANES(LANES), .DW(DW)) i_cmp (
        .data     (dat),
        .ctl      (lane_ctl),
        .active   (act),
        .cmp_data (fld_cmp),
        .mis      (mis)
    );

    always_comb begin
        code_d          = cls;
        code_d.cons_err = fld_err || (be_seen && miss_any);
        code_d.mis      = mis;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            start_q <= 1'b0;
        end else begin
            code_q  <= code_d;
            start_q <= start;
        end
    end

    assign ev_code   = code_q;
    assign pkt_start = start_q;

    // R2: active video never carries the consistency error
    p_video_noerr_r2: assert property (@(posedge clk) disable iff (rst)
        code_q.video |-> !code_q.cons_err);

    // R9: the consistency error only sits on blank-end or timing states
    p_err_subtype_r9: assert property (@(posedge clk) disable iff (rst)
        code_q.cons_err |-> (!code_q.video && (code_q.sub == ST_BE ||
            code_q.sub == ST_MVID || code_q.sub == ST_MAUD)));

    // R4: the strobe marks only packet-start subtypes in blanking
    p_strobe_start_r4: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (!code_q.video && (code_q.sub == ST_START ||
            code_q.sub == ST_BE || code_q.sub == ST_SSTART)));

    // R8: a single active lane can never disagree with itself
    p_single_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (lane_cnt == 2'd0) |=> !ev_code[0]);
endmodule

// File: tb/test_stream_event_coder.sv
module test_stream_event_coder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  lane_cnt = 2'd2;
    logic [31:0] lane_data = '0;
    logic [3:0]  lane_ctl = '0;
    logic [7:0]  ev_code;
    logic        pkt_start;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    stream_event_coder i_stream_event_coder (
        .clk       (clk),
        .rst       (rst),
        .lane_cnt  (lane_cnt),
        .lane_data (lane_data),
        .lane_ctl  (lane_ctl),
        .ev_code   (ev_code),
        .pkt_start (pkt_start)
    );

    // {lane_cnt, ctl[3:0], d0, d1, d2, d3, expected code, expected strobe, req}
    localparam int NV = 38;
    localparam logic [50:0] VEC [NV] = '{
        {2'd2, 4'hF, 8'hBC, 8'hBC, 8'hBC, 8'hBC, 8'h00, 1'b1, 4'd4},  // R4 blank start
        {2'd2, 4'h0, 8'h02, 8'h02, 8'h02, 8'h02, 8'h08, 1'b0, 4'd4},  // R4 flag byte
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 1'b0, 4'd4},  // R4 video timing
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 1'b0, 4'd4},  // R4 audio timing
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h18, 1'b0, 4'd4},  // R4 dummy
        {2'd2, 4'hF, 8'hFB, 8'hFB, 8'hFB, 8'hFB, 8'h04, 1'b1, 4'd5},  // R5 blank end
        {2'd2, 4'h0, 8'h55, 8'h55, 8'h55, 8'h55, 8'hC4, 1'b0, 4'd2},  // R2 pixel field 1
        {2'd2, 4'hF, 8'hFE, 8'hFE, 8'hFE, 8'hFE, 8'hC8, 1'b0, 4'd3},  // R3 fill start
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC8, 1'b0, 4'd3},  // R3 fill data
        {2'd2, 4'hF, 8'hF7, 8'hF7, 8'hF7, 8'hF7, 8'hC8, 1'b0, 4'd3},  // R3 fill end
        {2'd2, 4'h0, 8'h33, 8'h33, 8'h33, 8'h33, 8'hC4, 1'b0, 4'd3},  // R3 pixel again
        {2'd2, 4'hF, 8'hBC, 8'hBC, 8'hBC, 8'hBC, 8'h00, 1'b1, 4'd4},  // R4
        {2'd2, 4'h0, 8'h19, 8'h19, 8'h19, 8'h19, 8'h48, 1'b0, 4'd4},  // R4 vertical flag
        {2'd2, 4'h0, 8'h07, 8'h07, 8'h07, 8'h07, 8'h4E, 1'b0, 4'd9},  // R9 no-video
        {2'd2, 4'h0, 8'h05, 8'h05, 8'h05, 8'h05, 8'h52, 1'b0, 4'd10}, // R10 muted
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h58, 1'b0, 4'd12}, // R12 clean
        {2'd2, 4'hF, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 8'h54, 1'b1, 4'd6},  // R6 sec start
        {2'd2, 4'hF, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 1'b0, 4'd6},  // R6 attributes
        {2'd2, 4'h0, 8'h12, 8'h12, 8'h12, 8'h12, 8'h5C, 1'b0, 4'd6},  // R6 held
        {2'd2, 4'hF, 8'hFD, 8'hFD, 8'hFD, 8'hFD, 8'h5C, 1'b0, 4'd6},  // R6 end
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h58, 1'b0, 4'd6},  // R6 dummy after
        {2'd2, 4'hF, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 8'h54, 1'b1, 4'd6},  // R6
        {2'd2, 4'h0, 8'h01, 8'h01, 8'h01, 8'h01, 8'h64, 1'b0, 4'd6},  // R6 timestamp
        {2'd2, 4'hF, 8'hFD, 8'hFD, 8'hFD, 8'hFD, 8'h64, 1'b0, 4'd6},  // R6
        {2'd2, 4'hF, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 8'h54, 1'b1, 4'd6},  // R6
        {2'd2, 4'h0, 8'h02, 8'h02, 8'h02, 8'h02, 8'h60, 1'b0, 4'd6},  // R6 audio stream
        {2'd2, 4'hF, 8'hFD, 8'hFD, 8'hFD, 8'hFD, 8'h60, 1'b0, 4'd6},  // R6
        {2'd2, 4'hF, 8'h5C, 8'h5C, 8'h5C, 8'h5C, 8'h54, 1'b1, 4'd6},  // R6
        {2'd2, 4'h0, 8'h07, 8'h07, 8'h07, 8'h07, 8'h68, 1'b0, 4'd6},  // R6 other type
        {2'd2, 4'hF, 8'hFD, 8'hFD, 8'hFD, 8'hFD, 8'h68, 1'b0, 4'd6},  // R6
        {2'd2, 4'hF, 8'h1C, 8'h1C, 8'h1C, 8'hBC, 8'h41, 1'b1, 4'd7},  // R7 control differs
        {2'd2, 4'h0, 8'h01, 8'h01, 8'h03, 8'h01, 8'h49, 1'b0, 4'd7},  // R7 flag byte differs
        {2'd2, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h4C, 1'b0, 4'd12}, // R12 cleared
        {2'd2, 4'h0, 8'h09, 8'h09, 8'h09, 8'h09, 8'h50, 1'b0, 4'd10}, // R10 not muted
        {2'd2, 4'h2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h59, 1'b0, 4'd7},  // R7 ctl flag differs
        {2'd0, 4'hE, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h58, 1'b0, 4'd8},  // R8 one lane
        {2'd1, 4'h4, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h58, 1'b0, 4'd8},  // R8 lane 2 idle
        {2'd1, 4'h2, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h59, 1'b0, 4'd8}   // R8 lane 1 live
    };

    task automatic check(input string req, input logic [7:0] exp_code, input logic exp_stb);
        checks++;
        if (ev_code !== exp_code || pkt_start !== exp_stb) begin
            fails++;
            $display("FAIL %s: code=%h strobe=%b expected code=%h strobe=%b",
                     req, ev_code, pkt_start, exp_code, exp_stb);
        end
    endtask

    task automatic drive(input logic [1:0] cnt, input logic [3:0] k, input logic [7:0] v);
        lane_cnt  = cnt;
        lane_ctl  = k;
        lane_data = {v, v, v, v};
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
                finish_up();
            end
        end
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 1'b0);
        rst = 1'b0;
        for (int n = 0; n < NV; n++) begin
            lane_cnt  = VEC[n][50:49];
            lane_ctl  = VEC[n][48:45];
            lane_data = {VEC[n][20:13], VEC[n][28:21], VEC[n][36:29], VEC[n][44:37]};
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[n][3:0], n), VEC[n][12:5], VEC[n][4]);
        end

        // R11: reset symbol clears the blank-end count
        drive(2'd2, 4'hF, 8'h1C);
        check("R11 reset symbol", 8'h40, 1'b1);
        for (int n = 0; n < 300; n++) drive(2'd2, 4'hF, 8'hFB);
        drive(2'd2, 4'hF, 8'h1C);
        bad = 0;
        for (int n = 0; n < 511; n++) begin
            drive(2'd2, 4'hF, 8'hFB);
            if (ev_code !== 8'h44) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R11 early flag: bad states=%0d expected 0", bad);
        end
        drive(2'd2, 4'hF, 8'hFB);
        check("R11 512th blank end", 8'h46, 1'b1);
        drive(2'd2, 4'hF, 8'hFB);
        check("R12 after missed reset", 8'h44, 1'b1);

        // R1: reset mid-stream
        rst = 1'b1;
        drive(2'd2, 4'h0, 8'h55);
        check("R1 reset again", 8'h00, 1'b0);
        finish_up();
    end
endmodule